// File: doc/BRIEF.md
# Configurable Two-Port Synchronous RAM

A word-addressed memory with two ports, A and B, each able to write and read. Writes are masked by byte lane, so a port can update any subset of the lanes of the addressed word. A read is captured at the port's input clock edge into a per-port read latch. An optional output register per port then re-times that latch onto the port's output clock. A read enable gates the latch, so the output keeps its last value while no read is requested.

Two clock inputs and two clock enables serve the whole block. A compile-time mode parameter decides which clock drives each register group. In single mode, clock 0 drives everything. In read/write mode, port A (the write side) runs on clock 0 and port B (the read side) on clock 1, and port B writes are discarded. In input/output mode, clock 0 drives all input-side registers and clock 1 drives both output registers. In independent mode, each port runs on its own clock.

Registered outputs can be zeroed in two ways. The first is an asynchronous clear, which a per-port parameter can disconnect from either output. The second is a synchronous clear, which acts on the next enabled edge of the output clock. A read that meets a write to the same word in the same cycle returns the word as it was before the write.

Top module: `dualPortRam`

## Requirements
- R1: A write stores data only in the lanes whose bit in the port's lane-enable vector is 1. Bit i covers data bits [8i+7:8i] for the default 8-bit lane. All other lanes of the word keep their stored value.
- R2: With output registers on, read data appears on the port output after the second rising edge following the read request. It is not yet there after the first edge.
- R3: While a port's read enable is low, its output keeps its last value whatever the address does.
- R4: A read of a word in the same cycle that the other port or the same port writes it returns the value stored before that write. The new value is returned by the next read.
- R5: While a clock's enable is low, the registers driven by that clock hold. In input/output mode, clock-0 enable low discards writes, and clock-1 enable low freezes both outputs while reads still reach the latches.
- R6: Raising the asynchronous clear zeroes a port's registered output at once when that port's clear parameter is 1. It leaves the output unchanged when the parameter is 0. The read latch is not cleared.
- R7: The synchronous clear zeroes both registered outputs at an output-clock edge where that clock's enable is high. At an edge where that enable is low, it has no effect.
- R8: Data written through one port can be read back through the other port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk0 | input | 1 | First clock; its role is set by the mode parameter |
| clk1 | input | 1 | Second clock; unused in single mode |
| clkEn0 | input | 1 | Enable for all registers driven by clk0 |
| clkEn1 | input | 1 | Enable for all registers driven by clk1 |
| aclr | input | 1 | Asynchronous clear of the registered outputs, gated per port by parameter |
| sclr | input | 1 | Synchronous clear of the registered outputs |
| dataA | input | DATA_W | Port A write data |
| addrA | input | ADDR_W | Port A word address |
| wrEnA | input | 1 | Port A write enable; tie low when unused |
| rdEnA | input | 1 | Port A read enable |
| laneEnA | input | DATA_W/LANE_W | Port A lane-enable mask for writes |
| dataB | input | DATA_W | Port B write data |
| addrB | input | ADDR_W | Port B word address |
| wrEnB | input | 1 | Port B write enable |
| rdEnB | input | 1 | Port B read enable |
| laneEnB | input | DATA_W/LANE_W | Port B lane-enable mask for writes |
| qA | output | DATA_W | Port A read data, same width as dataA |
| qB | output | DATA_W | Port B read data, same width as dataB |

## Verification
The checks take for granted that the two ports never write the same word at the same edge of a shared input clock. That case is undefined, and one assertion exists only to flag it. They also assume the asynchronous clear, once raised, stays high across at least one output-clock edge, so that no load check straddles a clear pulse. The stimulus runs the block in input/output mode with one clock on both inputs. It changes every input on the falling edge, writes to different addresses or to only one port in every write cycle, and holds each clear pulse from one falling edge to the next.

// File: rtl/dpramPkg.sv
package dpramPkg;

  // Which clock drives which register group
  typedef enum logic [1:0] {
    CLK_SINGLE = 2'd0,
    CLK_RDWR   = 2'd1,
    CLK_INOUT  = 2'd2,
    CLK_INDEP  = 2'd3
  } clkMode_e;

  // Strobes from control to datapath, already qualified by clock enables
  typedef struct packed {
    logic wrA;
    logic rdA;
    logic outA;
    logic clrA;
    logic wrB;
    logic rdB;
    logic outB;
    logic clrB;
  } portStb_t;

endpackage

// File: rtl/dpramCtrl.sv
module dpramCtrl
  import dpramPkg::*;
#(
  parameter clkMode_e CLK_MODE = CLK_INDEP
) (
  input  logic     clk0,
  input  logic     clk1,
  input  logic     clkEn0,
  input  logic     clkEn1,
  input  logic     sclr,
  input  logic     wrEnA,
  input  logic     rdEnA,
  input  logic     wrEnB,
  input  logic     rdEnB,
  output logic     clkAIn,
  output logic     clkAOut,
  output logic     clkBIn,
  output logic     clkBOut,
  output portStb_t stb
);

  // 1 selects clk1 for that register group
  localparam bit SEL_A_IN  = 1'b0;
  localparam bit SEL_A_OUT = (CLK_MODE == CLK_INOUT);
  localparam bit SEL_B_IN  = (CLK_MODE == CLK_RDWR) || (CLK_MODE == CLK_INDEP);
  localparam bit SEL_B_OUT = (CLK_MODE != CLK_SINGLE);
  localparam bit B_WRITES  = (CLK_MODE != CLK_RDWR);

  logic enAIn, enAOut, enBIn, enBOut;

  assign clkAIn  = SEL_A_IN  ? clk1 : clk0;
  assign clkAOut = SEL_A_OUT ? clk1 : clk0;
  assign clkBIn  = SEL_B_IN  ? clk1 : clk0;
  assign clkBOut = SEL_B_OUT ? clk1 : clk0;

  assign enAIn  = SEL_A_IN  ? clkEn1 : clkEn0;
  assign enAOut = SEL_A_OUT ? clkEn1 : clkEn0;
  assign enBIn  = SEL_B_IN  ? clkEn1 : clkEn0;
  assign enBOut = SEL_B_OUT ? clkEn1 : clkEn0;

  always_comb begin
    stb.wrA  = wrEnA & enAIn;
    stb.rdA  = rdEnA & enAIn;
    stb.outA = enAOut;
    stb.clrA = sclr & enAOut;
    stb.wrB  = wrEnB & enBIn & B_WRITES;
    stb.rdB  = rdEnB & enBIn;
    stb.outB = enBOut;
    stb.clrB = sclr & enBOut;
  end

endmodule

// File: rtl/dpramOutStage.sv
module dpramOutStage #(
  parameter int W          = 32,
  parameter bit REGISTERED = 1'b1,
  parameter bit USE_ACLR   = 1'b1
) (
  input  logic         clk,
  input  logic         aclr,
  input  logic         load,
  input  logic         clr,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic aclrEff;
  assign aclrEff = USE_ACLR ? aclr : 1'b0;

  generate
    if (REGISTERED) begin : g_reg
      logic [W-1:0] qReg;

      always_ff @(posedge clk or posedge aclrEff) begin
        if (aclrEff)   qReg <= '0;
        else if (clr)  qReg <= '0;
        else if (load) qReg <= din;
      end

      assign dout = qReg;

      // R2: an enabled edge moves the read latch to the output
      a_r2_out_load: assert property (@(posedge clk) disable iff (aclr)
        load && !clr |=> dout == $past(din));

      // R7: synchronous clear zeroes the output
      a_r7_sync_clear: assert property (@(posedge clk) disable iff (aclr)
        clr |=> dout == '0);

      // R5: with the output clock disabled the output holds
      a_r5_out_hold: assert property (@(posedge clk) disable iff (aclr)
        !load && !clr |=> $stable(dout));

      if (USE_ACLR) begin : g_aclrChk
        // R6: a held asynchronous clear keeps the output at zero
        a_r6_async_clear: assert property (@(posedge clk) disable iff (clr)
          aclrEff && $past(aclrEff) |-> dout == '0);
      end
    end else begin : g_thru
      assign dout = din;
    end
  endgenerate

endmodule

// File: rtl/dpramData.sv
module dpramData
  import dpramPkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 6,
  parameter int LANE_W      = 8,
  parameter bit OUT_REG_A   = 1'b1,
  parameter bit OUT_REG_B   = 1'b1,
  parameter bit ACLR_A      = 1'b1,
  parameter bit ACLR_B      = 1'b1,
  parameter bit SAME_IN_CLK = 1'b0,
  localparam int LANES      = DATA_W / LANE_W,
  localparam int DEPTH      = 1 << ADDR_W
) (
  input  logic              clkAIn,
  input  logic              clkAOut,
  input  logic              clkBIn,
  input  logic              clkBOut,
  input  logic              aclr,
  input  portStb_t          stb,
  input  logic [ADDR_W-1:0] addrA,
  input  logic [DATA_W-1:0] dataA,
  input  logic [LANES-1:0]  laneEnA,
  input  logic [ADDR_W-1:0] addrB,
  input  logic [DATA_W-1:0] dataB,
  input  logic [LANES-1:0]  laneEnB,
  output logic [DATA_W-1:0] qA,
  output logic [DATA_W-1:0] qB
);

  // Each port owns one bank; the stored word is the XOR of both banks
  logic [DATA_W-1:0] bankA [DEPTH];
  logic [DATA_W-1:0] bankB [DEPTH];
  logic [DATA_W-1:0] latchA, latchB;
  logic [DATA_W-1:0] wordA, wordB;

  function automatic logic [DATA_W-1:0] mergeLanes(
    input logic [DATA_W-1:0] oldWord,
    input logic [DATA_W-1:0] newWord,
    input logic [LANES-1:0]  en
  );
    logic [DATA_W-1:0] r;
    r = oldWord;
    for (int i = 0; i < LANES; i++) begin
      if (en[i]) r[i*LANE_W +: LANE_W] = newWord[i*LANE_W +: LANE_W];
    end
    return r;
  endfunction

  assign wordA = bankA[addrA] ^ bankB[addrA];
  assign wordB = bankA[addrB] ^ bankB[addrB];

  always_ff @(posedge clkAIn) begin
    if (stb.wrA) bankA[addrA] <= mergeLanes(bankA[addrA], dataA ^ bankB[addrA], laneEnA);
    if (stb.rdA) latchA <= wordA;
  end

  always_ff @(posedge clkBIn) begin
    if (stb.wrB) bankB[addrB] <= mergeLanes(bankB[addrB], dataB ^ bankA[addrB], laneEnB);
    if (stb.rdB) latchB <= wordB;
  end

  dpramOutStage #(.W(DATA_W), .REGISTERED(OUT_REG_A), .USE_ACLR(ACLR_A)) u_outA (
    .clk (clkAOut),
    .aclr(aclr),
    .load(stb.outA),
    .clr (stb.clrA),
    .din (latchA),
    .dout(qA)
  );

  dpramOutStage #(.W(DATA_W), .REGISTERED(OUT_REG_B), .USE_ACLR(ACLR_B)) u_outB (
    .clk (clkBOut),
    .aclr(aclr),
    .load(stb.outB),
    .clr (stb.clrB),
    .din (latchB),
    .dout(qB)
  );

  // R3: read latches hold while their read strobe is low
  a_r3_latch_hold_a: assert property (@(posedge clkAIn) disable iff (aclr)
    !stb.rdA |=> $stable(latchA));
  a_r3_latch_hold_b: assert property (@(posedge clkBIn) disable iff (aclr)
    !stb.rdB |=> $stable(latchB));

  generate
    if (SAME_IN_CLK) begin : g_sameClkChk
      logic [ADDR_W-1:0] addrPrevA;
      logic [DATA_W-1:0] wordPrevA;

      always_ff @(posedge clkAIn) addrPrevA <= addrA;
      assign wordPrevA = bankA[addrPrevA] ^ bankB[addrPrevA];

      // R4: both ports writing one word at one edge is outside the contract
      a_r4_no_dual_write: assert property (@(posedge clkAIn) disable iff (aclr)
        !(stb.wrA && stb.wrB && addrA == addrB));

      // R1: only enabled lanes of the written word change
      a_r1_lane_merge: assert property (@(posedge clkAIn) disable iff (aclr)
        stb.wrA |=> wordPrevA == mergeLanes($past(wordA), $past(dataA), $past(laneEnA)));
    end
  endgenerate

endmodule

// File: rtl/dualPortRam.sv
module dualPortRam
  import dpramPkg::*;
#(
  parameter int       DATA_W    = 32,
  parameter int       ADDR_W    = 6,
  parameter int       LANE_W    = 8,
  parameter clkMode_e CLK_MODE  = CLK_INDEP,
  parameter bit       OUT_REG_A = 1'b1,
  parameter bit       OUT_REG_B = 1'b1,
  parameter bit       ACLR_A    = 1'b1,
  parameter bit       ACLR_B    = 1'b1,
  localparam int      LANES     = DATA_W / LANE_W
) (
  input  logic              clk0,
  input  logic              clk1,
  input  logic              clkEn0,
  input  logic              clkEn1,
  input  logic              aclr,
  input  logic              sclr,
  input  logic [DATA_W-1:0] dataA,
  input  logic [ADDR_W-1:0] addrA,
  input  logic              wrEnA,
  input  logic              rdEnA,
  input  logic [LANES-1:0]  laneEnA,
  input  logic [DATA_W-1:0] dataB,
  input  logic [ADDR_W-1:0] addrB,
  input  logic              wrEnB,
  input  logic              rdEnB,
  input  logic [LANES-1:0]  laneEnB,
  output logic [DATA_W-1:0] qA,
  output logic [DATA_W-1:0] qB
);

  localparam bit SAME_IN_CLK = (CLK_MODE == CLK_SINGLE) || (CLK_MODE == CLK_INOUT);

  logic     clkAIn, clkAOut, clkBIn, clkBOut;
  portStb_t stb;

  dpramCtrl #(.CLK_MODE(CLK_MODE)) u_ctrl (
    .clk0   (clk0),
    .clk1   (clk1),
    .clkEn0 (clkEn0),
    .clkEn1 (clkEn1),
    .sclr   (sclr),
    .wrEnA  (wrEnA),
    .rdEnA  (rdEnA),
    .wrEnB  (wrEnB),
    .rdEnB  (rdEnB),
    .clkAIn (clkAIn),
    .clkAOut(clkAOut),
    .clkBIn (clkBIn),
    .clkBOut(clkBOut),
    .stb    (stb)
  );

  dpramData #(
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .LANE_W     (LANE_W),
    .OUT_REG_A  (OUT_REG_A),
    .OUT_REG_B  (OUT_REG_B),
    .ACLR_A     (ACLR_A),
    .ACLR_B     (ACLR_B),
    .SAME_IN_CLK(SAME_IN_CLK)
  ) u_data (
    .clkAIn (clkAIn),
    .clkAOut(clkAOut),
    .clkBIn (clkBIn),
    .clkBOut(clkBOut),
    .aclr   (aclr),
    .stb    (stb),
    .addrA  (addrA),
    .dataA  (dataA),
    .laneEnA(laneEnA),
    .addrB  (addrB),
    .dataB  (dataB),
    .laneEnB(laneEnB),
    .qA     (qA),
    .qB     (qB)
  );

endmodule

// File: tb/sim_dualPortRam.sv
`timescale 1ns/1ps
module sim_dualPortRam;
  import dpramPkg::*;

  localparam int DW = 32;
  localparam int AW = 6;
  localparam int LN = DW / 8;

  logic          clk = 1'b0;
  logic          clkEn0, clkEn1, aclr, sclr;
  logic [DW-1:0] dataA, dataB;
  logic [AW-1:0] addrA, addrB;
  logic          wrEnA, rdEnA, wrEnB, rdEnB;
  logic [LN-1:0] laneEnA, laneEnB;
  logic [DW-1:0] qA, qB;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  dualPortRam #(
    .DATA_W(DW), .ADDR_W(AW), .LANE_W(8), .CLK_MODE(CLK_INOUT),
    .OUT_REG_A(1'b1), .OUT_REG_B(1'b1), .ACLR_A(1'b1), .ACLR_B(1'b0)
  ) u0 (
    .clk0(clk), .clk1(clk), .clkEn0(clkEn0), .clkEn1(clkEn1),
    .aclr(aclr), .sclr(sclr),
    .dataA(dataA), .addrA(addrA), .wrEnA(wrEnA), .rdEnA(rdEnA), .laneEnA(laneEnA),
    .dataB(dataB), .addrB(addrB), .wrEnB(wrEnB), .rdEnB(rdEnB), .laneEnB(laneEnB),
    .qA(qA), .qB(qB)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic writeA(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [LN-1:0] be);
    addrA = a; dataA = d; laneEnA = be; wrEnA = 1'b1;
    @(negedge clk);
    wrEnA = 1'b0;
  endtask

  task automatic writeB(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [LN-1:0] be);
    addrB = a; dataB = d; laneEnB = be; wrEnB = 1'b1;
    @(negedge clk);
    wrEnB = 1'b0;
  endtask

  task automatic readA(input logic [AW-1:0] a);
    addrA = a; rdEnA = 1'b1;
    @(negedge clk);
    rdEnA = 1'b0;
    @(negedge clk);
  endtask

  task automatic readB(input logic [AW-1:0] a);
    addrB = a; rdEnB = 1'b1;
    @(negedge clk);
    rdEnB = 1'b0;
    @(negedge clk);
  endtask

  task automatic tReset();
    repeat (3) @(negedge clk);
    check("R6 reset qA by async clear", qA, '0);
    check("R7 reset qB by sync clear", qB, '0);
    aclr = 1'b0;
    sclr = 1'b0;
    @(negedge clk);
  endtask

  task automatic tWriteRead();
    writeA(6'd3, 32'hDEADBEEF, 4'hF);
    readA(6'd3);
    check("R2 port A read back", qA, 32'hDEADBEEF);
    readB(6'd3);
    check("R8 port B reads port A write", qB, 32'hDEADBEEF);
  endtask

  task automatic tLaneMask();
    writeA(6'd3, 32'h11223344, 4'b0101);
    readA(6'd3);
    check("R1 lanes 0,2 from port A", qA, 32'hDE22BE44);
    writeB(6'd5, 32'h01020304, 4'hF);
    writeB(6'd5, 32'hAABBCCDD, 4'b1100);
    readA(6'd5);
    check("R1 R8 lanes 2,3 from port B", qA, 32'hAABB0304);
  endtask

  task automatic tReadHold();
    addrA = 6'd3; rdEnA = 1'b0;
    repeat (3) @(negedge clk);
    check("R3 output holds with read enable low", qA, 32'hAABB0304);
  endtask

  task automatic tLatency();
    addrA = 6'd3; rdEnA = 1'b1;
    @(negedge clk);
    rdEnA = 1'b0;
    check("R2 not visible after one edge", qA, 32'hAABB0304);
    @(negedge clk);
    check("R2 visible after two edges", qA, 32'hDE22BE44);
  endtask

  task automatic tCollision();
    writeA(6'd7, 32'h0, 4'hF);
    addrA = 6'd7; dataA = 32'hCAFEF00D; laneEnA = 4'hF; wrEnA = 1'b1;
    addrB = 6'd7; rdEnB = 1'b1;
    @(negedge clk);
    wrEnA = 1'b0; rdEnB = 1'b0;
    @(negedge clk);
    check("R4 cross-port read during write gives old", qB, 32'h0);
    readB(6'd7);
    check("R4 next read gives new", qB, 32'hCAFEF00D);
    addrA = 6'd7; dataA = 32'h12345678; wrEnA = 1'b1; rdEnA = 1'b1;
    @(negedge clk);
    wrEnA = 1'b0; rdEnA = 1'b0;
    @(negedge clk);
    check("R4 same-port read during write gives old", qA, 32'hCAFEF00D);
  endtask

  task automatic tClockEnable();
    clkEn1 = 1'b0;
    readA(6'd3);
    check("R5 output frozen with clock-1 enable low", qA, 32'hCAFEF00D);
    clkEn1 = 1'b1;
    @(negedge clk);
    check("R5 latched read appears once enabled", qA, 32'hDE22BE44);
    clkEn0 = 1'b0;
    writeA(6'd3, 32'hFFFFFFFF, 4'hF);
    clkEn0 = 1'b1;
    readA(6'd3);
    check("R5 write discarded with clock-0 enable low", qA, 32'hDE22BE44);
  endtask

  task automatic tAsyncClear();
    aclr = 1'b1;
    #1;
    check("R6 port A cleared at once", qA, '0);
    check("R6 port B not cleared", qB, 32'hCAFEF00D);
    @(negedge clk);
    aclr = 1'b0;
    @(negedge clk);
    check("R6 latch kept through clear", qA, 32'hDE22BE44);
  endtask

  task automatic tSyncClear();
    sclr = 1'b1;
    @(negedge clk);
    check("R7 port A zero after edge", qA, '0);
    check("R7 port B zero after edge", qB, '0);
    sclr = 1'b0;
    @(negedge clk);
    clkEn1 = 1'b0;
    sclr = 1'b1;
    @(negedge clk);
    check("R7 no clear while enable low", qA, 32'hDE22BE44);
    sclr = 1'b0;
    clkEn1 = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    clkEn0 = 1'b1; clkEn1 = 1'b1; aclr = 1'b1; sclr = 1'b1;
    dataA = '0; dataB = '0; addrA = '0; addrB = '0;
    wrEnA = 1'b0; rdEnA = 1'b0; wrEnB = 1'b0; rdEnB = 1'b0;
    laneEnA = '0; laneEnB = '0;
    tReset();
    tWriteRead();
    tLaneMask();
    tReadHold();
    tLatency();
    tCollision();
    tClockEnable();
    tAsyncClear();
    tSyncClear();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule